// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Bank

This block holds a row of single-bit storage cells behind one serial data input and a binary address. Two active-low controls, a write enable and a mode clear, pick one of four behaviours for each clock cycle. The first is a write of the selected cell. The second is a hold of every cell. The third steers the data bit onto one selected output and drives the rest low. The fourth zeroes the whole bank. A caller uses it to set or clear individual flag bits one at a time, or to route a single signal to one of many destinations.

Storage is a clocked register bank that updates on the rising edge, not a set of transparent latches. Writes become visible on the cycle after the edge. The steering and clearing modes override the outputs in the same cycle, without waiting for a clock edge. Steering leaves the stored contents untouched. Clearing also empties the storage at the next edge. The output count is two raised to the address width, which is eight by default.

Top module: `addr_latch_bank`

## Requirements
- R1: While `rst_ni` is low, storage is cleared asynchronously. With both controls high, `q_o` reads all zeros.
- R2: With `wr_en_ni` low and `clr_ni` high (write mode), cell `addr_i` takes `data_i` at the rising edge. `q_o` shows the new value from that edge onward.
- R3: In write mode, every cell other than the addressed one keeps its value across the edge.
- R4: With both controls high (hold mode), `q_o` shows the stored contents and does not change, whatever `data_i` and `addr_i` do.
- R5: With both controls low (steer mode), `q_o[addr_i]` equals `data_i` and every other output is 0, in the same cycle.
- R6: Steer mode writes no storage. On a return to hold mode, `q_o` shows the contents held before steering began.
- R7: With `wr_en_ni` high and `clr_ni` low (clear mode), `q_o` is all zeros in the same cycle, whatever `data_i` and `addr_i` do.
- R8: Clear mode zeroes storage at the rising edge. A following hold shows all zeros.
- R9: Between two consecutive write-mode cycles, `addr_i` changes in at most one bit. Callers make larger address moves in hold mode.
- R10: Address value k, read as unsigned binary with `addr_i[0]` as the least significant bit, selects output bit `q_o[k]`. Outputs are non-inverting with respect to `data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of storage |
| wr_en_ni | input | 1 | Active-low write/steer enable |
| clr_ni | input | 1 | Active-low clear/steer select |
| data_i | input | 1 | Serial data bit |
| addr_i | input | AW (3) | Cell/output select |
| q_o | output | N (8) | Output bits |

## Verification
The assertions check the cycle-level rules on every cycle. Hold mode keeps `q_o` stable. Steer mode shows exactly the data bit at the addressed position. Clear mode reads zero, and so does a hold that directly follows a clear. A write changes only the addressed bit, and the written-to-hold hand-off shows the written value. Write-mode address moves stay within one bit. Only the bench's scenarios can show three things: that steering across many cycles leaves storage intact for a later hold, that an asynchronous reset in mid-cycle empties the bank, and that a full Gray-code walk of writes builds the expected pattern.

// File: rtl/alb_pkg.sv
package alb_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_STEER = 2'd2,
    MODE_CLEAR = 2'd3
  } alb_mode_e;
endpackage

// File: rtl/alb_mode_dec.sv
module alb_mode_dec
  import alb_pkg::*;
(
  input  logic      wr_en_ni,
  input  logic      clr_ni,
  output alb_mode_e mode_o
);
  always_comb begin
    unique case ({wr_en_ni, clr_ni})
      2'b01:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_STEER;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alb_sel_dec.sv
module alb_sel_dec #(
  parameter int unsigned AW = 3,
  localparam int unsigned N = 1 << AW
) (
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);
  for (genvar k = 0; k < N; k++) begin : g_sel
    assign sel_o[k] = (addr_i == AW'(k));
  end
endmodule

// File: rtl/alb_store.sv
module alb_store
  import alb_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alb_mode_e    mode_i,
  input  logic [N-1:0] sel_i,
  input  logic         data_i,
  output logic [N-1:0] store_o
);
  for (genvar k = 0; k < N; k++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        store_o[k] <= 1'b0;
      end else if (mode_i == MODE_CLEAR) begin
        store_o[k] <= 1'b0;
      end else if (mode_i == MODE_WRITE && sel_i[k]) begin
        store_o[k] <= data_i;
      end
    end
  end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import alb_pkg::*;
#(
  parameter int unsigned AW = 3,
  localparam int unsigned N = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_ni,
  input  logic          clr_ni,
  input  logic          data_i,
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  q_o
);
  alb_mode_e    mode;
  logic [N-1:0] sel;
  logic [N-1:0] store;

  alb_mode_dec i_mode_dec (
    .wr_en_ni(wr_en_ni),
    .clr_ni  (clr_ni),
    .mode_o  (mode)
  );

  alb_sel_dec #(.AW(AW)) i_sel_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  alb_store #(.N(N)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .sel_i  (sel),
    .data_i (data_i),
    .store_o(store)
  );

  // steer and clear override the outputs at once; storage stays behind them
  always_comb begin
    unique case (mode)
      MODE_STEER: q_o = sel & {N{data_i}};
      MODE_CLEAR: q_o = '0;
      default:    q_o = store;
    endcase
  end
endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
  parameter int unsigned AW = 3,
  localparam int unsigned N = 1 << AW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_ni,
  input logic          clr_ni,
  input logic          data_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0]  q_o
);
  logic          past_ok;
  logic          was_write, was_hold, was_clear;
  logic [AW-1:0] prev_addr;
  logic          prev_data;
  logic [N-1:0]  prev_q;

  wire is_write = !wr_en_ni && clr_ni;
  wire is_hold  = wr_en_ni && clr_ni;
  wire is_steer = !wr_en_ni && !clr_ni;
  wire is_clear = wr_en_ni && !clr_ni;
  wire [N-1:0] prev_mask = N'(1) << prev_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok   <= 1'b0;
      was_write <= 1'b0;
      was_hold  <= 1'b0;
      was_clear <= 1'b0;
      prev_addr <= '0;
      prev_data <= 1'b0;
      prev_q    <= '0;
    end else begin
      past_ok   <= 1'b1;
      was_write <= is_write;
      was_hold  <= is_hold;
      was_clear <= is_clear;
      prev_addr <= addr_i;
      prev_data <= data_i;
      prev_q    <= q_o;
    end
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && was_hold && is_hold) |-> (q_o == prev_q));

  // R5
  steer_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_steer |-> ($countones(q_o) == 32'(data_i) && q_o[addr_i] == data_i));

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clear |-> (q_o == '0));

  // R8
  clear_persist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && was_clear && is_hold) |-> (q_o == '0));

  // R2
  write_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && was_write && is_hold) |-> (q_o[prev_addr] == prev_data));

  // R3
  write_others_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && was_write && (is_write || is_hold)) |-> (((q_o ^ prev_q) & ~prev_mask) == '0));

  // R9
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && was_write && is_write) |-> ($countones(addr_i ^ prev_addr) <= 1));
endmodule

bind addr_latch_bank addr_latch_bank_chk #(.AW(AW)) i_addr_latch_bank_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_ni(wr_en_ni),
  .clr_ni  (clr_ni),
  .data_i  (data_i),
  .addr_i  (addr_i),
  .q_o     (q_o)
);

// File: tb/test_addr_latch_bank.sv
module test_addr_latch_bank;
  localparam int unsigned AW = 3;
  localparam int unsigned N  = 1 << AW;
  localparam time CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG_CYCLES = 20000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_ni = 1'b1;
  logic          clr_ni = 1'b1;
  logic          data_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [N-1:0]  q_o;

  logic [N-1:0]  exp_store = '0;
  int            n_checks = 0;
  int            n_fails = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  addr_latch_bank #(.AW(AW)) i_addr_latch_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_ni(wr_en_ni),
    .clr_ni  (clr_ni),
    .data_i  (data_i),
    .addr_i  (addr_i),
    .q_o     (q_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: q_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_hold(input logic [AW-1:0] a);
    @(negedge clk_i);
    wr_en_ni = 1'b1; clr_ni = 1'b1; addr_i = a;
  endtask

  // one write cycle entered from hold, address set while holding
  task automatic write_bit(input logic [AW-1:0] a, input logic d);
    go_hold(a);
    @(negedge clk_i);
    wr_en_ni = 1'b0; data_i = d;
    @(posedge clk_i); #1;
    exp_store[a] = d;
    check("R2/R3/R10 write", q_o, exp_store);
    go_hold(a);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #(CLK_PERIOD * 2);
    check("R1 reset", q_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 after release", q_o, '0);
  endtask

  task automatic t_write();
    write_bit(3'd0, 1'b1);
    write_bit(3'd3, 1'b1);
    write_bit(3'd5, 1'b1);
    write_bit(3'd7, 1'b1);
    write_bit(3'd3, 1'b0);
    check("R10 pattern", q_o, 8'b1010_0001);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      wr_en_ni = 1'b1; clr_ni = 1'b1;
      addr_i = AW'(i * 5);
      data_i = i[0];
      #1;
      check("R4 hold mid-cycle", q_o, exp_store);
      @(posedge clk_i); #1;
      check("R4 hold after edge", q_o, exp_store);
    end
  endtask

  task automatic t_steer();
    for (int a = 0; a < N; a++) begin
      for (int d = 0; d < 2; d++) begin
        @(negedge clk_i);
        wr_en_ni = 1'b0; clr_ni = 1'b0;
        addr_i = AW'(a); data_i = d[0];
        #1;
        check("R5/R10 steer", q_o, d[0] ? (N'(1) << a) : '0);
        @(posedge clk_i); #1;
        check("R5 steer after edge", q_o, d[0] ? (N'(1) << a) : '0);
      end
    end
    go_hold(3'd0);
    #1;
    check("R6 storage kept", q_o, exp_store);
  endtask

  task automatic t_clear();
    @(negedge clk_i);
    wr_en_ni = 1'b1; clr_ni = 1'b0; addr_i = 3'd5; data_i = 1'b1;
    #1;
    check("R7 clear immediate", q_o, '0);
    @(posedge clk_i); #1;
    addr_i = 3'd2; data_i = 1'b0;
    #1;
    check("R7 clear ignores inputs", q_o, '0);
    exp_store = '0;
    go_hold(3'd2);
    #1;
    check("R8 storage cleared", q_o, '0);
  endtask

  // consecutive write cycles along a Gray sequence keep each step to one bit
  task automatic t_gray_walk();
    logic [AW-1:0] g;
    go_hold(3'd0);
    for (int i = 0; i < N; i++) begin
      g = AW'(i) ^ (AW'(i) >> 1);
      @(negedge clk_i);
      wr_en_ni = 1'b0; clr_ni = 1'b1; addr_i = g; data_i = ~g[1];
      @(posedge clk_i); #1;
      exp_store[g] = ~g[1];
      check("R2/R3/R9 gray walk", q_o, exp_store);
    end
    go_hold(3'd4);
    #1;
    check("R10 walk pattern", q_o, 8'b0011_0011);
  endtask

  task automatic t_async_reset();
    @(negedge clk_i);
    #2;
    rst_ni = 1'b0;
    #1;
    exp_store = '0;
    check("R1 async mid-cycle", q_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 stays empty", q_o, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_write();
    t_hold();
    t_steer();
    t_clear();
    t_gray_walk();
    t_async_reset();
    repeat (2) @(posedge clk_i);
    finish_run();
  end
endmodule